// File: doc/BRIEF.md
# Refresh Debt Scheduler

This block paces the refresh work of an asynchronous DRAM controller. A free-running cycle timer marks the end of every per-row refresh interval, and each such mark adds one unit to a refresh debt: a count of refreshes that are owed but not yet done. The controller reports every completed strobe-reversed (column strobe before row strobe) refresh with a one-cycle pulse, which pays one unit back. The DRAM's internal row counter picks the row, so the scheduler produces no address.

While any debt is outstanding the block raises a soft request, which the controller may put off in favour of host traffic. Once the debt reaches a configured threshold it also raises an urgent request, which the controller must serve ahead of host accesses. The debt saturates at a configured ceiling. The interval is set in clock cycles, normally the retention window divided by the row count (64 ms over 4096 rows is about 15.6 us, 1560 cycles at 100 MHz).

Top module: `refresh_debt_scheduler`

## Requirements
- R1: While rst_n is low, and at the first check after it, refresh_debt is 0 and refresh_req and refresh_urgent are low. The interval timer restarts from phase zero.
- R2: With no done pulse, refresh_debt rises by one at the INTERVAL_CYC-th rising clock edge after reset release, and again every INTERVAL_CYC edges after that.
- R3: refresh_debt never exceeds DEBT_MAX. An interval end that finds the debt at DEBT_MAX leaves it there.
- R4: A refresh_done pulse in a cycle with no interval end lowers a non-zero refresh_debt by one at the next edge.
- R5: A refresh_done pulse while refresh_debt is 0 and no interval ends is ignored: the debt stays 0 and refresh_req stays low.
- R6: An interval end and a refresh_done pulse in the same cycle leave refresh_debt unchanged.
- R7: refresh_req is high exactly when refresh_debt is greater than 0.
- R8: refresh_urgent is high exactly when refresh_debt is greater than or equal to URGENT_LVL.
- R9: refresh_done pulses neither restart nor stall the interval timer. Interval ends keep their fixed period whatever the done traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| refresh_done | input | 1 | One-cycle pulse per completed refresh cycle |
| refresh_req | output | 1 | Soft request: at least one refresh owed |
| refresh_urgent | output | 1 | Backlog at or above the urgent threshold |
| refresh_debt | output | DEBT_W | Current number of owed refreshes |

## Verification
The bench builds the block with INTERVAL_CYC=5, DEBT_MAX=6 and URGENT_LVL=4. With these values saturation is reached within about thirty cycles, the urgent threshold is crossed in both directions many times, and done pulses can be placed at every phase of the interval. A set of pulse patterns with periods 2 to 7, tried at every offset, plus a sweep that puts a lone pulse at each interval phase, covers coincident tick and done, paying off at zero, and draining from saturation. A second reset in the middle of traffic checks that the timer phase restarts.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  // Next debt value from the current value and the two events of a cycle.
  function automatic int debt_next(input int cur, input bit tick,
                                   input bit done, input int max_debt);
    int nxt;
    nxt = cur;
    if (tick && !done) begin
      if (cur < max_debt) nxt = cur + 1;
    end else if (done && !tick) begin
      if (cur > 0) nxt = cur - 1;
    end
    return nxt;
  endfunction

  // Next timer phase; wraps at the end of the interval.
  function automatic int phase_next(input int cur, input int interval);
    return (cur >= interval - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
  parameter int INTERVAL_CYC = 1560,
  parameter int CNT_W        = $clog2(INTERVAL_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [CNT_W-1:0] phase
);
  import refsch_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign tick  = (cnt_q == CNT_W'(INTERVAL_CYC - 1));
  assign phase = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(phase_next(32'(cnt_q), INTERVAL_CYC));
  end

endmodule

// File: rtl/refsch_debt_counter.sv
module refsch_debt_counter #(
  parameter int DEBT_MAX = 15,
  parameter int DEBT_W   = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              done,
  output logic [DEBT_W-1:0] debt
);
  import refsch_pkg::*;

  logic [DEBT_W-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= DEBT_W'(debt_next(32'(debt_q), tick, done, DEBT_MAX));
  end

  assign debt = debt_q;

endmodule

// File: rtl/refsch_request_flags.sv
module refsch_request_flags #(
  parameter int DEBT_W     = 4,
  parameter int URGENT_LVL = 8
) (
  input  logic [DEBT_W-1:0] debt,
  output logic              req,
  output logic              urgent
);

  assign req = |debt;

  generate
    if (URGENT_LVL <= 0) begin : g_always_urgent
      assign urgent = 1'b1;
    end else begin : g_threshold
      assign urgent = (32'(debt) >= URGENT_LVL);
    end
  endgenerate

endmodule

// File: rtl/refresh_debt_scheduler.sv
module refresh_debt_scheduler #(
  parameter int INTERVAL_CYC = 1560,
  parameter int DEBT_MAX     = 15,
  parameter int URGENT_LVL   = 8,
  localparam int DEBT_W      = $clog2(DEBT_MAX + 1),
  localparam int CNT_W       = $clog2(INTERVAL_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_done,
  output logic              refresh_req,
  output logic              refresh_urgent,
  output logic [DEBT_W-1:0] refresh_debt
);

  logic              tick_w;
  logic [CNT_W-1:0]  phase_w;
  logic [DEBT_W-1:0] debt_w;

  refsch_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .CNT_W       (CNT_W)
  ) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w),
    .phase(phase_w)
  );

  refsch_debt_counter #(
    .DEBT_MAX(DEBT_MAX),
    .DEBT_W  (DEBT_W)
  ) debt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w),
    .done (refresh_done),
    .debt (debt_w)
  );

  refsch_request_flags #(
    .DEBT_W    (DEBT_W),
    .URGENT_LVL(URGENT_LVL)
  ) flags_i (
    .debt  (debt_w),
    .req   (refresh_req),
    .urgent(refresh_urgent)
  );

  assign refresh_debt = debt_w;

endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
  parameter int DEBT_MAX = 15,
  parameter int DEBT_W   = 4,
  parameter int CNT_W    = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              done,
  input logic [DEBT_W-1:0] debt,
  input logic [CNT_W-1:0]  phase,
  input logic              req,
  input logic              urgent
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(debt) <= DEBT_MAX);

  p_tick_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done && 32'(debt) < DEBT_MAX) |=> (32'(debt) == 32'($past(debt)) + 1));

  p_tick_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done && 32'(debt) == DEBT_MAX) |=> $stable(debt));

  p_done_pays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && done && debt != '0) |=> (32'(debt) + 1 == 32'($past(debt))));

  p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && done && debt == '0) |=> (debt == '0 && !req));

  p_coincide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && done) |=> $stable(debt));

  p_req_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(tick));

  p_urgent_implies_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);

  p_timer_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == '0 && !tick));

endmodule

bind refresh_debt_scheduler refsch_checker #(
  .DEBT_MAX(DEBT_MAX),
  .DEBT_W  (DEBT_W),
  .CNT_W   (CNT_W)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick_w),
  .done  (refresh_done),
  .debt  (debt_w),
  .phase (phase_w),
  .req   (refresh_req),
  .urgent(refresh_urgent)
);

// File: tb/refresh_debt_scheduler_tb.sv
`timescale 1ns/1ps
module refresh_debt_scheduler_tb_top;

  localparam int INT = 5;
  localparam int MAX = 6;
  localparam int URG = 4;
  localparam int DW  = $clog2(MAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          done = 1'b0;
  logic          req;
  logic          urgent;
  logic [DW-1:0] debt;

  int checks = 0;
  int failures = 0;
  int m_debt = 0;
  int m_phase = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  refresh_debt_scheduler #(
    .INTERVAL_CYC(INT),
    .DEBT_MAX    (MAX),
    .URGENT_LVL  (URG)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .refresh_done  (done),
    .refresh_req   (req),
    .refresh_urgent(urgent),
    .refresh_debt  (debt)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock with refresh_done = d; model updated, outputs checked after the edge.
  task automatic step(input bit d);
    bit    tk;
    string tag;
    done = d;
    @(posedge clk);
    #1;
    tk = (m_phase == INT - 1);
    if (tk && d)                   tag = "R6";
    else if (tk && m_debt == MAX)  tag = "R3";
    else if (tk)                   tag = "R2";
    else if (d && m_debt == 0)     tag = "R5";
    else if (d)                    tag = "R4";
    else                           tag = "R9";
    if (tk && !d)               m_debt = (m_debt + 1 > MAX) ? MAX : m_debt + 1;
    else if (d && !tk && m_debt > 0) m_debt = m_debt - 1;
    m_phase = tk ? 0 : m_phase + 1;
    check(tag, int'(debt), m_debt);
    check("R7", int'(req), (m_debt > 0) ? 1 : 0);
    check("R8", int'(urgent), (m_debt >= URG) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    done  = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(debt), 0);
    check("R1", int'(req), 0);
    check("R1", int'(urgent), 0);
    @(negedge clk);
    rst_n   = 1'b1;
    done    = 1'b0;
    m_debt  = 0;
    m_phase = 0;
  endtask

  initial begin
    do_reset();
    // R2: first interval end exactly INT edges after release
    for (int i = 0; i < INT - 1; i++) begin
      step(1'b0);
      check("R2", int'(debt), 0);
    end
    step(1'b0);
    check("R2", int'(debt), 1);
    // R3: idle long enough to saturate
    for (int i = 0; i < 8 * INT; i++) step(1'b0);
    check("R3", int'(debt), MAX);
    // R4/R5: drain and keep pulsing past zero
    for (int i = 0; i < MAX + 6; i++) step(1'b1);
    // pattern sweep: period m at every offset k
    for (int m = 2; m <= 7; m++)
      for (int k = 0; k < m; k++)
        for (int i = 0; i < 3 * INT; i++) step(((i + k) % m) == 0);
    // R6/R9: lone pulse at each timer phase, preceded by some debt
    for (int off = 0; off < INT; off++) begin
      for (int i = 0; i < 2 * INT; i++) step(1'b0);
      for (int i = 0; i < 2 * INT; i++) step(m_phase == off);
    end
    // R1: reset in the middle of traffic restarts the phase
    for (int i = 0; i < 3; i++) step(1'b0);
    do_reset();
    for (int i = 0; i < 2 * INT; i++) step(1'b0);
    check("R2", int'(debt), 2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule